// File: doc/BRIEF.md
# Modulo 2^n−K Residue Adder

This block adds two residues of one residue-number-system channel whose modulus has the form M = 2^W − KVAL. Both operands must already be reduced into 0..M−1, and the result is (a+b) mod M. Instead of comparing against M and subtracting, the adder builds A+B+KVAL. The carry out of that sum at weight 2^W shows whether the plain sum reached the modulus. The wrapped value (A+B+KVAL) mod 2^W is the answer when that carry is set.

The datapath has two prefix stages. Stage one compresses a, b and the constant KVAL with a row of full adders. A parallel-prefix network then resolves the result: a generate/propagate pre-process, a log-depth tree of black, grey and pass cells, and a sum XOR. It yields the wrapped value and the wrap carry. Stage two is a flagged-prefix adder. When no wrap occurred, it adds the one's complement of KVAL to the wrapped value and then inverts selected sum bits under flag bits, which supplies the +1 of the two's complement. The result is the unwrapped sum, produced without a final multiplexer. When a wrap occurred, its operand and flags are gated off and the wrapped value passes through unchanged. An optional output register, with asynchronous active-low reset, follows the core.

Top module: `modk_adder`

## Requirements
- R1: The modulus is M = 2^W − KVAL. Elaboration stops with an error unless 3 ≤ KVAL ≤ 2^(W−1). With the defaults (W=7, KVAL=45) M is 83, so a=M−1, b=0 gives M−1 and a=1, b=M−1 gives 0.
- R2: For operands in 0..M−1 whose sum is below M, res equals a+b.
- R3: For operands in 0..M−1 whose sum is M or more, res equals a+b−M, and stage two then contributes nothing.
- R4: An operand pair summing to exactly M gives res = 0.
- R5: a = b = M−1 gives res = M−2.
- R6: res never leaves the range 0..M−1.
- R7: With OUT_REG=1, res takes the result one rising clk edge after the operands are applied and holds its value between edges. With OUT_REG=0 the path is combinational.
- R8: While rst_n is low the registered res reads 0, and it clears as soon as rst_n falls, without waiting for a clock.
- R9: The same RTL serves any odd or even width from 7 upward. Among others it serves W=15 with KVAL=15001 (M=17767), where R2–R6 hold unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| opnd_a | input | W | First residue, 0..M−1 |
| opnd_b | input | W | Second residue, 0..M−1 |
| res | output | W | (opnd_a + opnd_b) mod M |

## Verification
The assertions assume that both operands are already in 0..M−1 on every clock edge outside reset. A dedicated property flags any violation, because an unreduced operand would break the bound A+B+KVAL < 2^(W+1) that the single wrap carry relies on. The stimulus keeps within this domain: the 7-bit channel walks every legal pair, and the 15-bit channel draws operands from $urandom_range bounded by M−1. The directed pairs sit exactly on M−1, M and 2M−2. The mid-run reset keeps legal operands on the pins.

// File: rtl/modk_pkg.sv
package modk_pkg;

  // generate / propagate pair of one bit or one bit group
  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // pre-process cell: bitwise generate and half-sum
  function automatic gp_t cell_pre(input logic x, input logic y);
    gp_t r;
    r.g = x & y;
    r.p = x ^ y;
    return r;
  endfunction

  // black cell: group generate and group propagate
  function automatic gp_t cell_black(input gp_t hi, input gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

  // grey cell: group generate only, for groups that reach bit 0
  function automatic gp_t cell_grey(input gp_t hi, input gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/modk_csa.sv
module modk_csa #(
  parameter int W = 7
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] s,
  output logic [W-1:0] c
);

  // one full adder per bit, carry kept at the same index (weight 2^(i+1))
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign s[i] = x[i] ^ y[i] ^ z[i];
    assign c[i] = (x[i] & y[i]) | (x[i] & z[i]) | (y[i] & z[i]);
  end

endmodule

// File: rtl/modk_flag_apply.sv
module modk_flag_apply #(
  parameter int W = 7
) (
  input  logic [W-1:0] s_raw,
  input  logic [W-1:0] grp_p,
  input  logic         g_all,
  input  logic         inc,
  output logic [W-1:0] s_out,
  output logic         cout
);

  logic [W-1:0] flag;

  // flag for bit i: all lower bits propagate, so a +1 would ripple into i
  assign flag  = {grp_p[W-2:0], 1'b1};
  assign s_out = s_raw ^ (flag & {W{inc}});
  assign cout  = g_all | (inc & grp_p[W-1]);

endmodule

// File: rtl/modk_prefix.sv
module modk_prefix #(
  parameter int W         = 7,
  parameter bit FULL_PROP = 1'b1
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         inc,
  output logic [W-1:0] sum,
  output logic         cout
);
  import modk_pkg::*;

  localparam int LV = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0] gv [LV+1];
  logic [W-1:0] pv [LV+1];
  logic [W-1:0] half;
  logic [W-1:0] carry_in;
  logic [W-1:0] s_raw;

  // pre-process
  for (genvar i = 0; i < W; i++) begin : g_pre
    assign {gv[0][i], pv[0][i]} = cell_pre(x[i], y[i]);
  end
  assign half = pv[0];

  // Sklansky tree: at level l every bit with bit l set joins the group
  // ending just below its aligned block of size 2^l
  for (genvar l = 0; l < LV; l++) begin : g_lvl
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (((i >> l) & 1) == 1) begin : g_join
        localparam int J = ((i >> l) << l) - 1;
        if (FULL_PROP || ((i >> (l + 1)) != 0)) begin : g_black
          assign {gv[l+1][i], pv[l+1][i]} =
            cell_black({gv[l][i], pv[l][i]}, {gv[l][J], pv[l][J]});
        end else begin : g_grey
          assign {gv[l+1][i], pv[l+1][i]} =
            cell_grey({gv[l][i], pv[l][i]}, {gv[l][J], pv[l][J]});
        end
      end else begin : g_pass
        assign gv[l+1][i] = gv[l][i];
        assign pv[l+1][i] = pv[l][i];
      end
    end
  end

  // post-process: carry into bit i is group generate of bits i-1..0
  assign carry_in = {gv[LV][W-2:0], 1'b0};
  assign s_raw    = half ^ carry_in;

  modk_flag_apply #(.W(W)) u_flag (
    .s_raw (s_raw),
    .grp_p (pv[LV]),
    .g_all (gv[LV][W-1]),
    .inc   (inc),
    .s_out (sum),
    .cout  (cout)
  );

endmodule

// File: rtl/modk_adder.sv
module modk_adder #(
  parameter int W       = 7,
  parameter int KVAL    = 45,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] res
);

  localparam logic [W-1:0] K_VEC = W'(KVAL);

  if ((KVAL < 3) || (KVAL > (1 << (W - 1)))) begin : g_bad_k
    $error("modk_adder: KVAL must lie in 3..2^(W-1)");
  end

  logic [W-1:0] csa_s;
  logic [W-1:0] csa_c;
  logic [W-1:0] csa_w;
  logic [W-1:0] wrap_sum;
  logic         wrap_c0;
  logic         wrap_c;
  logic [W-1:0] fix_y;
  logic         fix_c;
  logic [W-1:0] comb_res;

  // stage 1: a + b + K through a 3:2 row and a generate-only prefix tree
  modk_csa #(.W(W)) u_csa (
    .x (opnd_a),
    .y (opnd_b),
    .z (K_VEC),
    .s (csa_s),
    .c (csa_c)
  );

  assign csa_w = {csa_c[W-2:0], 1'b0};

  modk_prefix #(.W(W), .FULL_PROP(1'b0)) u_wrap (
    .x    (csa_s),
    .y    (csa_w),
    .inc  (1'b0),
    .sum  (wrap_sum),
    .cout (wrap_c0)
  );

  // total is below 2^(W+1), so at most one of the two weight-2^W carries is set
  assign wrap_c = wrap_c0 | csa_c[W-1];

  // stage 2: no wrap -> add ~K and flag-increment (undo K); wrap -> pass through
  assign fix_y = ~K_VEC & {W{~wrap_c}};

  modk_prefix #(.W(W), .FULL_PROP(1'b1)) u_fix (
    .x    (wrap_sum),
    .y    (fix_y),
    .inc  (~wrap_c),
    .sum  (comb_res),
    .cout (fix_c)
  );

  if (OUT_REG) begin : g_reg
    logic [W-1:0] res_d;
    logic [W-1:0] res_q;

    always_comb begin
      res_d = comb_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q <= '0;
      end else begin
        res_q <= res_d;
      end
    end

    assign res = res_q;
  end else begin : g_comb
    assign res = comb_res;
  end

endmodule

// File: rtl/modk_adder_chk.sv
module modk_adder_chk #(
  parameter int W       = 7,
  parameter int KVAL    = 45,
  parameter bit OUT_REG = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [W-1:0] res,
  input logic         wrap_c,
  input logic         fix_c
);

  localparam int M = (1 << W) - KVAL;

  logic primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed <= 1'b0;
    end else begin
      primed <= 1'b1;
    end
  end

  function automatic int raw(input logic [W-1:0] x, input logic [W-1:0] y);
    return int'(x) + int'(y);
  endfunction

  // operand domain taken for granted by everything below (R2)
  a_r2_legal_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(opnd_a) < M) && (int'(opnd_b) < M));

  a_r6_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(res) < M);

  // the correction stage carries out exactly when stage 1 did not wrap (R3)
  a_r3_carry_pair: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_c != fix_c);

  if (OUT_REG) begin : g_seq
    a_r2_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      primed && (raw($past(opnd_a), $past(opnd_b)) < M)
      |-> int'(res) == raw($past(opnd_a), $past(opnd_b)));

    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      primed && (raw($past(opnd_a), $past(opnd_b)) >= M)
      |-> int'(res) == raw($past(opnd_a), $past(opnd_b)) - M);

    a_r4_exact_zero: assert property (@(posedge clk) disable iff (!rst_n)
      primed && (raw($past(opnd_a), $past(opnd_b)) == M)
      |-> int'(res) == 0);

    a_r5_max_pair: assert property (@(posedge clk) disable iff (!rst_n)
      primed && (int'($past(opnd_a)) == M - 1) && (int'($past(opnd_b)) == M - 1)
      |-> int'(res) == M - 2);

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      primed && $stable(opnd_a) && $stable(opnd_b) |=> $stable(res));
  end else begin : g_comb
    a_r2_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (raw(opnd_a, opnd_b) < M) |-> int'(res) == raw(opnd_a, opnd_b));

    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (raw(opnd_a, opnd_b) >= M) |-> int'(res) == raw(opnd_a, opnd_b) - M);

    a_r4_exact_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (raw(opnd_a, opnd_b) == M) |-> int'(res) == 0);

    a_r5_max_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(opnd_a) == M - 1) && (int'(opnd_b) == M - 1) |-> int'(res) == M - 2);
  end

endmodule

bind modk_adder modk_adder_chk #(
  .W       (W),
  .KVAL    (KVAL),
  .OUT_REG (OUT_REG)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .opnd_a (opnd_a),
  .opnd_b (opnd_b),
  .res    (res),
  .wrap_c (wrap_c),
  .fix_c  (fix_c)
);

// File: tb/tb_modk_adder.sv
module tb_modk_adder;

  localparam int K7  = 45;
  localparam int M7  = 128 - K7;
  localparam int K15 = 15001;
  localparam int M15 = 32768 - K15;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  a7, b7;
  logic [14:0] a15, b15;
  logic [6:0]  r7;
  logic [14:0] r15;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int prev7  = 0;
  int prev15 = 0;

  always #4 clk = ~clk;  // 125 MHz

  modk_adder #(.W(7), .KVAL(K7), .OUT_REG(1'b1)) dut (
    .clk (clk), .rst_n (rst_n), .opnd_a (a7), .opnd_b (b7), .res (r7)
  );

  modk_adder #(.W(15), .KVAL(K15), .OUT_REG(1'b1)) dut_w15 (
    .clk (clk), .rst_n (rst_n), .opnd_a (a15), .opnd_b (b15), .res (r15)
  );

  function automatic int mexp(input int x, input int y, input int m);
    return (x + y >= m) ? (x + y - m) : (x + y);
  endfunction

  function automatic string tag_of(input int x, input int y, input int m);
    if ((x == m - 1) && (y == m - 1)) return "R5";
    if (x + y == m)                    return "R4";
    if (x + y < m)                     return "R2";
    return "R3";
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive both channels at a falling edge, confirm the register holds (R7),
  // then check the new result one rising edge later
  task automatic step(input int x7, input int y7, input int x15, input int y15,
                      input string t7);
    @(negedge clk);
    a7  = 7'(x7);
    b7  = 7'(y7);
    a15 = 15'(x15);
    b15 = 15'(y15);
    #1;
    chk("R7 hold w7", int'(r7), prev7);
    chk("R7 hold w15", int'(r15), prev15);
    @(negedge clk);
    prev7  = mexp(x7, y7, M7);
    prev15 = mexp(x15, y15, M15);
    chk(t7, int'(r7), prev7);
    chk({"R9 ", tag_of(x15, y15, M15)}, int'(r15), prev15);
    chk("R6", int'(r7 < 7'(M7)), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7001));
    rst_n = 1'b0;
    a7 = 7'd5;  b7 = 7'd9;  a15 = 15'd300; b15 = 15'd400;
    repeat (3) @(negedge clk);
    chk("R8 reset w7", int'(r7), 0);
    chk("R8 reset w15", int'(r15), 0);
    rst_n = 1'b1;
    @(negedge clk);
    prev7  = mexp(5, 9, M7);
    prev15 = mexp(300, 400, M15);
    chk("R7 first edge w7", int'(r7), prev7);

    // directed corners
    step(M7 - 1, 0, M15 - 1, 0, "R1 top value");
    step(1, M7 - 1, 1, M15 - 1, "R1 R4 one plus top");
    step(0, 0, 0, 0, "R2 zero");
    step(M7 - 1, M7 - 1, M15 - 1, M15 - 1, "R5 max pair");
    step(40, 43, 8000, M15 - 8000, "R4 exact modulus");
    step(41, 41, 8883, 8882, "R2 just below");
    step(42, 42, 8884, 8884, "R3 just above");
    step(M7 - 1, 1, M15 - 2, 2, "R4 edge");

    // exhaustive 7-bit channel, random 15-bit channel
    for (int x = 0; x < M7; x++) begin
      for (int y = 0; y < M7; y++) begin
        step(x, y, int'($urandom_range(M15 - 1, 0)),
             int'($urandom_range(M15 - 1, 0)), tag_of(x, y, M7));
      end
    end

    // asynchronous reset in mid run
    @(negedge clk);
    a7 = 7'd30; b7 = 7'd31;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R8 async clear w7", int'(r7), 0);
    chk("R8 async clear w15", int'(r15), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    prev7  = mexp(int'(a7), int'(b7), M7);
    prev15 = mexp(int'(a15), int'(b15), M15);
    chk("R8 restart w7", int'(r7), prev7);

    // extra random pairs on both channels
    for (int n = 0; n < 1500; n++) begin
      int x7 = int'($urandom_range(M7 - 1, 0));
      int y7 = int'($urandom_range(M7 - 1, 0));
      step(x7, y7, int'($urandom_range(M15 - 1, 0)),
           int'($urandom_range(M15 - 1, 0)), tag_of(x7, y7, M7));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule